// File: doc/BRIEF.md
# Crypto Engine Context-Save Sequencer

This block walks through a crypto engine's secret state and hands it, one 128-bit block at a time, to a downstream memory writer over a valid/ready stream. A single save command, accepted only while the auto-save enable input is high, starts a fixed walk. The walk covers a random block, the sticky configuration blocks, the key-slot table, the RSA key store and, when the public-key accelerator option is built in and selected, its sticky block and key store. A fixed known-pattern block closes the stream so that a reader can confirm the stream is complete and in order.

The engine's state is read through a fetch port. The block names the section and the index of the block it is currently presenting, and the engine returns that block's contents in the same cycle. The random block is taken from an external random source. A progress counter counts accepted blocks and is cleared only by reset, so one save is allowed per reset. Software compares the counter with the expected total. An interrupt status register holds a done bit and a rejected-command bit, and each bit is cleared by writing a 1 to it.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, busy_o, ctx_valid_o, blk_count_o and int_stat_o are all zero.
- R2: A save_cmd_i pulse while auto_en_i is low has no effect. busy_o and blk_count_o stay zero and no status bit is set.
- R3: In base mode the stream carries 132 blocks in this order: 1 random block, 2 sticky blocks, 64 key-table blocks, 64 RSA blocks and 1 pattern block. st_sec_o gives the section being presented (0 random, 1 sticky, 2 key table, 3 RSA, 4 accelerator sticky, 5 accelerator keys, 6 pattern) and st_idx_o gives the index within that section, counting up from 0. In the key table, idx[5:2] is the slot and idx[1:0] is the kind: 0 and 1 are key blocks, 2 is the original IV and 3 is the updated IV. The random block carries rnd_i, the pattern block carries the KNOWN_PAT parameter, and every other block carries st_data_i.
- R4: When the accelerator option is built in and pka_en_i is high at the start, 1 accelerator sticky block (section 4) and 512 accelerator key blocks (section 5) are inserted between the RSA section and the pattern block, for 645 blocks in total.
- R5: blk_count_o rises by exactly one for each cycle in which ctx_valid_o and ctx_ready_i are both high, and is otherwise unchanged. While ctx_ready_i is low, the presented section and index hold, and no block is lost or repeated.
- R6: On the clock edge that accepts the pattern block, busy_o and ctx_valid_o fall, int_stat_o bit 0 (done) is set, and blk_count_o equals 132 in base mode or 645 in extended mode.
- R7: An enabled save_cmd_i while busy_o is high or while blk_count_o is nonzero is rejected. int_stat_o bit 1 is set, no new walk starts, and the running walk and the counter are unaffected.
- R8: When int_clr_we_i is high, each int_stat_o bit whose int_clr_i bit is 1 is cleared and the other bits are kept. A bit that is being set in the same cycle stays set.
- R9: With ctx_ready_i held high, one block is accepted every clock. A base save keeps busy_o high for exactly 132 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_en_i | input | 1 | Auto-save enable; save commands are ignored while low |
| pka_en_i | input | 1 | Select extended mode; sampled at the start of a save |
| save_cmd_i | input | 1 | Save command pulse |
| int_clr_we_i | input | 1 | Write strobe for the status clear |
| int_clr_i | input | 2 | Write-1-to-clear mask for int_stat_o |
| int_stat_o | output | 2 | Bit 0 done, bit 1 rejected command |
| busy_o | output | 1 | A save is in progress |
| blk_count_o | output | CNT_W (10) | Number of blocks accepted since reset |
| rnd_i | input | BLK_W (128) | Random block from the random source |
| st_sec_o | output | 3 | Section code of the block being presented |
| st_idx_o | output | IDX_W (10) | Index within the section of the block being presented |
| st_data_i | input | BLK_W (128) | Engine state block for st_sec_o/st_idx_o, same cycle |
| ctx_valid_o | output | 1 | Stream valid |
| ctx_ready_i | input | 1 | Stream ready from the writer |
| ctx_data_o | output | BLK_W (128) | Stream block |

## Verification
The hardest case to reach is a second command while a save is running but the counter still reads zero. In that case the rejection comes only from the busy condition, because the counter check alone would let the command through. The stimulus reaches this window by holding ctx_ready_i low right after the start, so that no block is accepted. It then pulses the command and releases the stream to confirm that the walk and the final total are unaffected. A separate stream with pseudo-random backpressure checks that stalls neither drop nor repeat blocks, including stalls at the section boundaries.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

   typedef enum logic [2:0] {
      SEC_RAND    = 3'd0,
      SEC_STICKY  = 3'd1,
      SEC_KEYS    = 3'd2,
      SEC_RSA     = 3'd3,
      SEC_PK_STKY = 3'd4,
      SEC_PK_KEYS = 3'd5,
      SEC_PATTERN = 3'd6
   } ctx_sec_e;

   localparam int IRQ_W      = 2;
   localparam int IRQ_DONE   = 0;
   localparam int IRQ_REJECT = 1;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ctx_walk.sv
module ctx_walk
   import ctx_save_pkg::*;
#(
   parameter int IDX_W       = 10,
   parameter int STICKY_BLKS = 2,
   parameter int KEY_BLKS    = 64,
   parameter int RSA_BLKS    = 64,
   parameter int PK_KEY_BLKS = 512,
   parameter bit HAS_PKA     = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             pka_i,
   input  logic             adv_i,
   output logic             active_o,
   output logic             fin_o,
   output ctx_sec_e         sec_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_STICKY = IDX_W'(STICKY_BLKS - 1);
   localparam logic [IDX_W-1:0] LAST_KEYS   = IDX_W'(KEY_BLKS - 1);
   localparam logic [IDX_W-1:0] LAST_RSA    = IDX_W'(RSA_BLKS - 1);
   localparam logic [IDX_W-1:0] LAST_PKKEY  = IDX_W'(PK_KEY_BLKS - 1);

   logic             pka_ok;
   logic             pka_run;
   logic [IDX_W-1:0] last_idx;
   logic             sec_end;
   ctx_sec_e         sec_nxt;

   generate
      if (HAS_PKA) begin : g_pka
         assign pka_ok = pka_i;
      end else begin : g_nopka
         assign pka_ok = pka_i & 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (sec_o)
         SEC_STICKY:  last_idx = LAST_STICKY;
         SEC_KEYS:    last_idx = LAST_KEYS;
         SEC_RSA:     last_idx = LAST_RSA;
         SEC_PK_KEYS: last_idx = LAST_PKKEY;
         default:     last_idx = '0;
      endcase
   end

   always_comb begin
      unique case (sec_o)
         SEC_RAND:    sec_nxt = SEC_STICKY;
         SEC_STICKY:  sec_nxt = SEC_KEYS;
         SEC_KEYS:    sec_nxt = SEC_RSA;
         SEC_RSA:     sec_nxt = pka_run ? SEC_PK_STKY : SEC_PATTERN;
         SEC_PK_STKY: sec_nxt = SEC_PK_KEYS;
         default:     sec_nxt = SEC_PATTERN;
      endcase
   end

   assign sec_end = (idx_o == last_idx);
   assign fin_o   = active_o && adv_i && sec_end && (sec_o == SEC_PATTERN);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_o <= 1'b0;
         pka_run  <= 1'b0;
         sec_o    <= SEC_RAND;
         idx_o    <= '0;
      end else if (start_i) begin
         active_o <= 1'b1;
         pka_run  <= pka_ok;
         sec_o    <= SEC_RAND;
         idx_o    <= '0;
      end else if (active_o && adv_i) begin
         if (sec_end) begin
            idx_o <= '0;
            if (sec_o == SEC_PATTERN) begin
               active_o <= 1'b0;
            end else begin
               sec_o <= sec_nxt;
            end
         end else begin
            idx_o <= idx_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctx_blk_mux.sv
module ctx_blk_mux
   import ctx_save_pkg::*;
#(
   parameter int               BLK_W     = 128,
   parameter logic [BLK_W-1:0] KNOWN_PAT = '0
) (
   input  ctx_sec_e         sec_i,
   input  logic [BLK_W-1:0] rnd_i,
   input  logic [BLK_W-1:0] st_data_i,
   output logic [BLK_W-1:0] blk_o
);

   always_comb begin
      unique case (sec_i)
         SEC_RAND:    blk_o = rnd_i;
         SEC_PATTERN: blk_o = KNOWN_PAT;
         default:     blk_o = st_data_i;
      endcase
   end

endmodule

// File: rtl/ctx_irq_stat.sv
module ctx_irq_stat #(
   parameter int W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);

   logic [W-1:0] clr_mask;

   assign clr_mask = clr_we_i ? clr_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_o <= '0;
      end else begin
         stat_o <= (stat_o & ~clr_mask) | set_i;
      end
   end

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
   import ctx_save_pkg::*;
#(
   parameter int                BLK_W       = 128,
   parameter int                KEY_SLOTS   = 16,
   parameter int                BLK_PER_KEY = 4,
   parameter int                STICKY_BLKS = 2,
   parameter int                RSA_BLKS    = 64,
   parameter int                PK_KEY_BLKS = 512,
   parameter bit                HAS_PKA     = 1'b1,
   parameter logic [BLK_W-1:0]  KNOWN_PAT   = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
   localparam int KEY_BLKS = KEY_SLOTS * BLK_PER_KEY,
   localparam int TOT_BASE = 1 + STICKY_BLKS + KEY_BLKS + RSA_BLKS + 1,
   localparam int TOT_EXT  = TOT_BASE + 1 + PK_KEY_BLKS,
   localparam int MAX_SEC  = ctx_save_pkg::imax(ctx_save_pkg::imax(STICKY_BLKS, KEY_BLKS),
                                                ctx_save_pkg::imax(RSA_BLKS, PK_KEY_BLKS)),
   localparam int IDX_W    = $clog2(MAX_SEC + 1),
   localparam int CNT_W    = $clog2(TOT_EXT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             auto_en_i,
   input  logic             pka_en_i,
   input  logic             save_cmd_i,
   input  logic             int_clr_we_i,
   input  logic [1:0]       int_clr_i,
   output logic [1:0]       int_stat_o,
   output logic             busy_o,
   output logic [CNT_W-1:0] blk_count_o,
   input  logic [BLK_W-1:0] rnd_i,
   output logic [2:0]       st_sec_o,
   output logic [IDX_W-1:0] st_idx_o,
   input  logic [BLK_W-1:0] st_data_i,
   output logic             ctx_valid_o,
   input  logic             ctx_ready_i,
   output logic [BLK_W-1:0] ctx_data_o
);

   if (BLK_W < 32) begin : g_bad_blk
      $error("ctx_save_seq: BLK_W must be at least 32");
   end
   if (KEY_SLOTS < 1 || BLK_PER_KEY < 1) begin : g_bad_keys
      $error("ctx_save_seq: key table must hold at least one block");
   end
   if (STICKY_BLKS < 1 || RSA_BLKS < 1 || PK_KEY_BLKS < 1) begin : g_bad_sec
      $error("ctx_save_seq: every section needs at least one block");
   end

   ctx_sec_e         sec;
   logic             cmd_ok;
   logic             start;
   logic             reject;
   logic             adv;
   logic             fin;
   logic [IRQ_W-1:0] irq_set;
   logic [CNT_W-1:0] blk_cnt;

   assign cmd_ok = save_cmd_i && auto_en_i;
   assign start  = cmd_ok && !busy_o && (blk_cnt == '0);
   assign reject = cmd_ok && !start;
   assign adv    = ctx_valid_o && ctx_ready_i;

   ctx_walk #(
      .IDX_W       (IDX_W),
      .STICKY_BLKS (STICKY_BLKS),
      .KEY_BLKS    (KEY_BLKS),
      .RSA_BLKS    (RSA_BLKS),
      .PK_KEY_BLKS (PK_KEY_BLKS),
      .HAS_PKA     (HAS_PKA)
   ) u_walk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .pka_i    (pka_en_i),
      .adv_i    (adv),
      .active_o (busy_o),
      .fin_o    (fin),
      .sec_o    (sec),
      .idx_o    (st_idx_o)
   );

   ctx_blk_mux #(
      .BLK_W     (BLK_W),
      .KNOWN_PAT (KNOWN_PAT)
   ) u_mux (
      .sec_i     (sec),
      .rnd_i     (rnd_i),
      .st_data_i (st_data_i),
      .blk_o     (ctx_data_o)
   );

   always_comb begin
      irq_set             = '0;
      irq_set[IRQ_DONE]   = fin;
      irq_set[IRQ_REJECT] = reject;
   end

   ctx_irq_stat #(
      .W (IRQ_W)
   ) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (irq_set),
      .clr_we_i (int_clr_we_i),
      .clr_i    (int_clr_i),
      .stat_o   (int_stat_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         blk_cnt <= '0;
      end else if (adv) begin
         blk_cnt <= blk_cnt + 1'b1;
      end
   end

   assign blk_count_o = blk_cnt;
   assign ctx_valid_o = busy_o;
   assign st_sec_o    = sec;

endmodule

// File: rtl/ctx_save_chk.sv
module ctx_save_chk #(
   parameter int CNT_W    = 10,
   parameter int IDX_W    = 10,
   parameter int TOT_BASE = 132,
   parameter int TOT_EXT  = 645
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             auto_en_i,
   input logic             save_cmd_i,
   input logic             busy_o,
   input logic [CNT_W-1:0] blk_count_o,
   input logic [1:0]       int_stat_o,
   input logic [2:0]       st_sec_o,
   input logic [IDX_W-1:0] st_idx_o,
   input logic             ctx_valid_o,
   input logic             ctx_ready_i
);

   // R2: a command without the enable starts nothing
   assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      save_cmd_i && !auto_en_i && !busy_o |=> !busy_o);

   // R3: sections advance one step at a time, skipping the accelerator pair only
   assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctx_valid_o && $past(ctx_valid_o) && (st_sec_o != $past(st_sec_o)) |->
      (st_sec_o == $past(st_sec_o) + 3'd1) ||
      (($past(st_sec_o) == 3'd3) && (st_sec_o == 3'd6)));

   // R5: a stalled block stays presented
   assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctx_valid_o && !ctx_ready_i |=>
      ctx_valid_o && $stable(st_sec_o) && $stable(st_idx_o));

   // R5: counter moves by one per accepted transfer and never otherwise
   assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctx_valid_o && ctx_ready_i |=> blk_count_o == CNT_W'($past(blk_count_o) + 1'b1));

   assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ctx_valid_o && ctx_ready_i) |=> $stable(blk_count_o));

   // R6: the end of a save raises done and leaves a full total in the counter
   assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> int_stat_o[0]);

   assert_total_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (blk_count_o == CNT_W'(TOT_BASE)) || (blk_count_o == CNT_W'(TOT_EXT)));

   // R7: an enabled command while busy or after a save is flagged
   assert_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      save_cmd_i && auto_en_i && (busy_o || (blk_count_o != '0)) |=> int_stat_o[1]);

endmodule

bind ctx_save_seq ctx_save_chk #(
   .CNT_W    (CNT_W),
   .IDX_W    (IDX_W),
   .TOT_BASE (TOT_BASE),
   .TOT_EXT  (TOT_EXT)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .auto_en_i   (auto_en_i),
   .save_cmd_i  (save_cmd_i),
   .busy_o      (busy_o),
   .blk_count_o (blk_count_o),
   .int_stat_o  (int_stat_o),
   .st_sec_o    (st_sec_o),
   .st_idx_o    (st_idx_o),
   .ctx_valid_o (ctx_valid_o),
   .ctx_ready_i (ctx_ready_i)
);

// File: tb/ctx_save_seq_tb_top.sv
module ctx_save_seq_tb_top;

   localparam logic [127:0] PAT = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEED_FACE;
   localparam logic [127:0] RND = 128'h1357_9BDF_2468_ACE0_0F0F_F0F0_5555_AAAA;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         auto_en_i = 1'b0;
   logic         pka_en_i = 1'b0;
   logic         save_cmd_i = 1'b0;
   logic         int_clr_we_i = 1'b0;
   logic [1:0]   int_clr_i = 2'b00;
   logic [1:0]   int_stat_o;
   logic         busy_o;
   logic [9:0]   blk_count_o;
   logic [127:0] rnd_i = RND;
   logic [2:0]   st_sec_o;
   logic [9:0]   st_idx_o;
   logic [127:0] st_data_i;
   logic         ctx_valid_o;
   logic         ctx_ready_i = 1'b0;
   logic [127:0] ctx_data_o;

   int checks = 0;
   int errs = 0;
   logic [15:0] lf = 16'hACE1;

   always #2 clk_i = ~clk_i;

   function automatic logic [127:0] stm(input logic [2:0] s, input logic [9:0] i);
      return {16'hC7A5, 13'd0, s, 22'd0, i, ~{22'd0, i}, 32'h0BAD_F00D ^ {29'd0, s}};
   endfunction

   assign st_data_i = stm(st_sec_o, st_idx_o);

   ctx_save_seq #(
      .HAS_PKA   (1'b1),
      .KNOWN_PAT (PAT)
   ) dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .auto_en_i    (auto_en_i),
      .pka_en_i     (pka_en_i),
      .save_cmd_i   (save_cmd_i),
      .int_clr_we_i (int_clr_we_i),
      .int_clr_i    (int_clr_i),
      .int_stat_o   (int_stat_o),
      .busy_o       (busy_o),
      .blk_count_o  (blk_count_o),
      .rnd_i        (rnd_i),
      .st_sec_o     (st_sec_o),
      .st_idx_o     (st_idx_o),
      .st_data_i    (st_data_i),
      .ctx_valid_o  (ctx_valid_o),
      .ctx_ready_i  (ctx_ready_i),
      .ctx_data_o   (ctx_data_o)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int seclen(input int s, input bit ext);
      case (s)
         1: return 2;
         2: return 64;
         3: return 64;
         5: return 512;
         default: return 1;
      endcase
   endfunction

   function automatic int nxtsec(input int s, input bit ext);
      if (s == 3) return ext ? 4 : 6;
      return s + 1;
   endfunction

   function automatic logic [127:0] expdat(input int s, input int i);
      if (s == 0) return RND;
      if (s == 6) return PAT;
      return stm(3'(s), 10'(i));
   endfunction

   task automatic do_reset();
      rst_ni = 1'b0;
      auto_en_i = 1'b0; pka_en_i = 1'b0; save_cmd_i = 1'b0;
      int_clr_we_i = 1'b0; int_clr_i = 2'b00; ctx_ready_i = 1'b0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
   endtask

   task automatic pulse_cmd();
      save_cmd_i = 1'b1;
      @(negedge clk_i);
      save_cmd_i = 1'b0;
   endtask

   // Runs the stream to completion from a negedge with busy high.
   task automatic stream(input bit ext, input bit bp, output int n, output int bad, output int cyc);
      int es = 0;
      int ei = 0;
      n = 0; bad = 0; cyc = 0;
      while (busy_o && cyc < 5000) begin
         ctx_ready_i = bp ? lf[0] : 1'b1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (ctx_valid_o && ctx_ready_i) begin
            if (st_sec_o != 3'(es) || st_idx_o != 10'(ei) || ctx_data_o != expdat(es, ei)) begin
               if (bad == 0)
                  $display("stream mismatch at block %0d: sec %0d idx %0d, want sec %0d idx %0d",
                           n, st_sec_o, st_idx_o, es, ei);
               bad++;
            end
            n++;
            ei++;
            if (ei == seclen(es, ext)) begin
               ei = 0;
               es = nxtsec(es, ext);
            end
         end
         cyc++;
         @(negedge clk_i);
      end
      ctx_ready_i = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(busy_o == 1'b0, "R1 busy after reset", 128'(busy_o), 0);
      chk(ctx_valid_o == 1'b0, "R1 valid after reset", 128'(ctx_valid_o), 0);
      chk(blk_count_o == 10'd0, "R1 count after reset", 128'(blk_count_o), 0);
      chk(int_stat_o == 2'b00, "R1 status after reset", 128'(int_stat_o), 0);
   endtask

   task automatic t_disabled();
      do_reset();
      ctx_ready_i = 1'b1;
      pulse_cmd();
      repeat (3) @(negedge clk_i);
      chk(busy_o == 1'b0, "R2 busy with enable low", 128'(busy_o), 0);
      chk(blk_count_o == 10'd0, "R2 count with enable low", 128'(blk_count_o), 0);
      chk(int_stat_o == 2'b00, "R2 status with enable low", 128'(int_stat_o), 0);
      ctx_ready_i = 1'b0;
   endtask

   task automatic t_base();
      int n, bad, cyc;
      do_reset();
      auto_en_i = 1'b1;
      pulse_cmd();
      chk(int_stat_o == 2'b00, "R6 no done while running", 128'(int_stat_o), 0);
      stream(1'b0, 1'b0, n, bad, cyc);
      chk(bad == 0, "R3 base order and data", 128'(bad), 0);
      chk(n == 132, "R3 base block total", 128'(n), 132);
      chk(cyc == 132, "R9 one block per cycle", 128'(cyc), 132);
      chk(blk_count_o == 10'd132, "R6 base final count", 128'(blk_count_o), 132);
      chk(int_stat_o == 2'b01, "R6 done bit", 128'(int_stat_o), 1);
      chk(busy_o == 1'b0, "R6 idle after save", 128'(busy_o), 0);
   endtask

   task automatic t_backpressure();
      int n, bad, cyc;
      do_reset();
      auto_en_i = 1'b1;
      pulse_cmd();
      stream(1'b0, 1'b1, n, bad, cyc);
      chk(bad == 0, "R5 order under backpressure", 128'(bad), 0);
      chk(n == 132, "R5 no loss or repeat", 128'(n), 132);
      chk(cyc > 132, "R5 stalls happened", 128'(cyc), 133);
      chk(blk_count_o == 10'd132, "R5 count equals accepted", 128'(blk_count_o), 132);
   endtask

   task automatic t_ext_rearm();
      int n, bad, cyc;
      do_reset();
      auto_en_i = 1'b1;
      pka_en_i = 1'b1;
      pulse_cmd();
      pka_en_i = 1'b0;
      stream(1'b1, 1'b0, n, bad, cyc);
      chk(bad == 0, "R4 extended order and data", 128'(bad), 0);
      chk(n == 645, "R4 extended block total", 128'(n), 645);
      chk(blk_count_o == 10'd645, "R6 extended final count", 128'(blk_count_o), 645);
      // second trigger after completion
      ctx_ready_i = 1'b1;
      pulse_cmd();
      @(negedge clk_i);
      chk(busy_o == 1'b0, "R7 no restart after save", 128'(busy_o), 0);
      chk(int_stat_o == 2'b11, "R7 reject flagged", 128'(int_stat_o), 3);
      chk(blk_count_o == 10'd645, "R7 count unchanged", 128'(blk_count_o), 645);
      ctx_ready_i = 1'b0;
      // per-bit clear
      int_clr_we_i = 1'b1; int_clr_i = 2'b01;
      @(negedge clk_i);
      int_clr_we_i = 1'b0; int_clr_i = 2'b00;
      chk(int_stat_o == 2'b10, "R8 clear done only", 128'(int_stat_o), 2);
      // mask without strobe does nothing
      int_clr_i = 2'b10;
      @(negedge clk_i);
      chk(int_stat_o == 2'b10, "R8 mask ignored without strobe", 128'(int_stat_o), 2);
      // set wins over clear in the same cycle
      int_clr_we_i = 1'b1; save_cmd_i = 1'b1;
      @(negedge clk_i);
      int_clr_we_i = 1'b0; save_cmd_i = 1'b0;
      chk(int_stat_o == 2'b10, "R8 set beats clear", 128'(int_stat_o), 2);
      int_clr_we_i = 1'b1;
      @(negedge clk_i);
      int_clr_we_i = 1'b0; int_clr_i = 2'b00;
      chk(int_stat_o == 2'b00, "R8 clear reject", 128'(int_stat_o), 0);
   endtask

   task automatic t_busy_reject();
      int n, bad, cyc;
      do_reset();
      auto_en_i = 1'b1;
      pulse_cmd();
      @(negedge clk_i);
      pulse_cmd();
      chk(int_stat_o == 2'b10, "R7 reject while busy at zero count", 128'(int_stat_o), 2);
      chk(busy_o == 1'b1 && blk_count_o == 10'd0, "R7 walk untouched", 128'({busy_o, blk_count_o}), 128'({1'b1, 10'd0}));
      chk(st_sec_o == 3'd0 && st_idx_o == 10'd0, "R5 held first block", 128'({st_sec_o, st_idx_o}), 0);
      stream(1'b0, 1'b0, n, bad, cyc);
      chk(bad == 0 && n == 132, "R7 running save completes", 128'(n), 132);
      chk(int_stat_o == 2'b11, "R6 done after rejected command", 128'(int_stat_o), 3);
   endtask

   bit finished = 1'b0;

   initial begin
      t_reset();
      t_disabled();
      t_base();
      t_backpressure();
      t_ext_rearm();
      t_busy_reject();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!finished) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

endmodule